// File: doc/BRIEF.md
# Sequential Outer-Bank Register Loader

This block holds the outer bank registers of a multi-game cartridge. The CPU fills all of these registers through one write address. An internal slot pointer decides which register the next byte goes into. After each accepted write the pointer moves on by one. When it passes the last slot it returns to slot 0, so a software routine loads the whole set with a burst of consecutive writes to the same address.

Each accepted write also produces a one-cycle refresh pulse. This pulse tells the downstream bank logic, on both the program side and the pattern side, to recompute its mappings from the new contents. The block only stores and sequences the registers. It does not interpret their fields. Reads are not decoded.

Top module: `outer_bank_loader`

## Requirements
- R1: A write is accepted only when `cpu_wr` is high in a clock cycle and `cpu_addr` equals 16'h6000 on all 16 bits.
- R2: A write with `cpu_wr` high to any other address has no effect. This includes addresses that differ from 16'h6000 in a single bit and all other addresses from 16'h6001 to 16'h7FFF. Such a write leaves the registers and the slot pointer unchanged and raises no refresh.
- R3: An accepted write stores `cpu_data` into the register selected by the slot pointer. The new value is visible on `outer_regs` right after that clock edge. Register i occupies bits [8*i+7 : 8*i].
- R4: The slot pointer starts at 0 and moves to the next slot after each accepted write. After slot 3 it returns to 0, so the fifth write overwrites register 0.
- R5: `refresh` is high for exactly the one cycle that follows each accepted write. It is low after any cycle without an accepted write.
- R6: With `cpu_wr` low, nothing changes, even when `cpu_addr` is 16'h6000.
- R7: While `rst` is high at a clock edge, the pointer, all four registers and `refresh` are cleared to 0.
- R8: Accepted writes on consecutive cycles each land in the next slot. During the burst, `refresh` stays high on every cycle after an accepted write.
- R9: A reset in the middle of a load sequence makes the next accepted write land in register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, one write per cycle when high |
| outer_regs | output | 32 | Four outer registers, register i in bits [8*i+7:8*i] |
| refresh | output | 1 | One-cycle pulse requesting bank recomputation |

## Verification
The bench goes after the points where a plausible design goes wrong.

- **Address decode.** It sweeps single-bit neighbours of the load address and a spread of other addresses in the 0x6000 window. A decoder that ignores low address bits would accept these writes, and the data would land in a slot.
- **Pointer wrap.** 256 back-to-back loads run the pointer through many wraps. A pointer that saturates or skips a slot would put bytes in the wrong register.
- **Pointer hold.** Strobe-low and non-matching writes are mixed into the sequence. A pointer that advances on them would shift every later write by one slot.
- **Reset mid-sequence.** A reset lands in the middle of a sequence. A pointer that is not cleared would send the next byte somewhere other than register 0.

// File: rtl/obl_pkg.sv
package obl_pkg;

    localparam int          OBL_ADDR_W    = 16;
    localparam int          OBL_DATA_W    = 8;
    localparam int          OBL_NUM_SLOTS = 4;
    localparam logic [15:0] OBL_LOAD_ADDR = 16'h6000;

    // Classification of one bus cycle by the address decoder
    typedef enum logic [1:0] {
        WK_IDLE = 2'd0,   // strobe low
        WK_LOAD = 2'd1,   // strobe high, exact address hit
        WK_MISS = 2'd2    // strobe high, other address
    } wr_kind_e;

    function automatic int slot_ptr_width(input int slots);
        return (slots > 1) ? $clog2(slots) : 1;
    endfunction

endpackage

// File: rtl/obl_addr_decode.sv
module obl_addr_decode
    import obl_pkg::*;
#(
    parameter int                ADDR_W    = OBL_ADDR_W,
    parameter logic [ADDR_W-1:0] LOAD_ADDR = OBL_LOAD_ADDR
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output wr_kind_e          kind
);

    always_comb begin
        if (!wr) begin
            kind = WK_IDLE;
        end else if (addr == LOAD_ADDR) begin
            kind = WK_LOAD;
        end else begin
            kind = WK_MISS;
        end
    end

endmodule

// File: rtl/obl_slot_ptr.sv
module obl_slot_ptr
    import obl_pkg::*;
#(
    parameter int NUM_SLOTS = OBL_NUM_SLOTS,
    localparam int PTR_W    = slot_ptr_width(NUM_SLOTS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    output logic [PTR_W-1:0] slot
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_SLOTS - 1);

    logic [PTR_W-1:0] slot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
        end else if (advance) begin
            if (slot_q == LAST) begin
                slot_q <= '0;
            end else begin
                slot_q <= slot_q + 1'b1;
            end
        end
    end

    assign slot = slot_q;

    // R4: each accepted write moves to the next slot, wrapping after the last
    p_ptr_step_r4: assert property (@(posedge clk) disable iff (rst)
        advance |=> (slot == (($past(slot) == LAST) ? '0 : $past(slot) + 1'b1)));

    // R2 / R6: cycles without an accepted write leave the pointer alone
    p_ptr_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(slot));

    // R4: the pointer never leaves the slot range
    p_ptr_range_r4: assert property (@(posedge clk) disable iff (rst)
        slot <= LAST);

endmodule

// File: rtl/obl_slot_bank.sv
module obl_slot_bank
    import obl_pkg::*;
#(
    parameter int NUM_SLOTS = OBL_NUM_SLOTS,
    parameter int DATA_W    = OBL_DATA_W,
    localparam int PTR_W    = slot_ptr_width(NUM_SLOTS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        we,
    input  logic [PTR_W-1:0]            sel,
    input  logic [DATA_W-1:0]           din,
    output logic [NUM_SLOTS*DATA_W-1:0] q_flat
);

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        logic [DATA_W-1:0] q;
        logic              hit;

        assign hit = we && (sel == PTR_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (hit) begin
                q <= din;
            end
        end

        assign q_flat[i*DATA_W +: DATA_W] = q;

        // R3: a write selecting this slot lands here on the next edge
        p_slot_load_r3: assert property (@(posedge clk) disable iff (rst)
            (we && sel == PTR_W'(i)) |=> (q_flat[i*DATA_W +: DATA_W] == $past(din)));

        // R3: slots not selected keep their contents
        p_slot_keep_r3: assert property (@(posedge clk) disable iff (rst)
            !(we && sel == PTR_W'(i)) |=> $stable(q_flat[i*DATA_W +: DATA_W]));
    end

endmodule

// File: rtl/outer_bank_loader.sv
module outer_bank_loader
    import obl_pkg::*;
#(
    parameter int                ADDR_W    = OBL_ADDR_W,
    parameter int                DATA_W    = OBL_DATA_W,
    parameter int                NUM_SLOTS = OBL_NUM_SLOTS,
    parameter logic [ADDR_W-1:0] LOAD_ADDR = OBL_LOAD_ADDR
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [ADDR_W-1:0]           cpu_addr,
    input  logic [DATA_W-1:0]           cpu_data,
    input  logic                        cpu_wr,
    output logic [NUM_SLOTS*DATA_W-1:0] outer_regs,
    output logic                        refresh
);

    localparam int PTR_W = slot_ptr_width(NUM_SLOTS);

    wr_kind_e         kind;
    logic             load;
    logic [PTR_W-1:0] slot;
    logic             refresh_q;

    obl_addr_decode #(
        .ADDR_W    (ADDR_W),
        .LOAD_ADDR (LOAD_ADDR)
    ) u_decode (
        .addr (cpu_addr),
        .wr   (cpu_wr),
        .kind (kind)
    );

    assign load = (kind == WK_LOAD);

    obl_slot_ptr #(
        .NUM_SLOTS (NUM_SLOTS)
    ) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .advance (load),
        .slot    (slot)
    );

    obl_slot_bank #(
        .NUM_SLOTS (NUM_SLOTS),
        .DATA_W    (DATA_W)
    ) u_bank (
        .clk    (clk),
        .rst    (rst),
        .we     (load),
        .sel    (slot),
        .din    (cpu_data),
        .q_flat (outer_regs)
    );

    // Refresh follows the write by one edge, aligned with the new register value
    always_ff @(posedge clk) begin
        if (rst) begin
            refresh_q <= 1'b0;
        end else begin
            refresh_q <= load;
        end
    end

    assign refresh = refresh_q;

    // R2 / R6: misses and idle cycles leave every register unchanged
    p_miss_no_effect_r2: assert property (@(posedge clk) disable iff (rst)
        (kind != WK_LOAD) |=> $stable(outer_regs));

    // R5: a pulse follows every accepted write
    p_refresh_after_load_r5: assert property (@(posedge clk) disable iff (rst)
        (kind == WK_LOAD) |=> refresh);

    // R5: no pulse without an accepted write
    p_refresh_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (kind != WK_LOAD) |=> !refresh);

    // R7: reset clears the registers and the pulse
    p_reset_clear_r7: assert property (@(posedge clk)
        rst |=> (outer_regs == '0 && !refresh));

endmodule

// File: tb/sim_outer_bank_loader.sv
`timescale 1ns/1ps
module sim_outer_bank_loader;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cpu_addr;
    logic [7:0]  cpu_data;
    logic        cpu_wr;
    logic [31:0] outer_regs;
    logic        refresh;

    int  errors = 0;
    int  checks = 0;
    bit  done   = 0;

    logic [7:0] em [4];
    int         ep;

    always #2 clk = ~clk;

    outer_bank_loader u0 (
        .clk        (clk),
        .rst        (rst),
        .cpu_addr   (cpu_addr),
        .cpu_data   (cpu_data),
        .cpu_wr     (cpu_wr),
        .outer_regs (outer_regs),
        .refresh    (refresh)
    );

    function automatic logic [31:0] exp_flat();
        return {em[3], em[2], em[1], em[0]};
    endfunction

    task automatic check_state(input bit exp_pulse, input string tag);
        checks++;
        if (outer_regs !== exp_flat()) begin
            errors++;
            $display("FAIL %s: outer_regs=%h expected %h", tag, outer_regs, exp_flat());
        end
        checks++;
        if (refresh !== exp_pulse) begin
            errors++;
            $display("FAIL %s: refresh=%b expected %b", tag, refresh, exp_pulse);
        end
    endtask

    // One bus cycle; the expected state is updated from the requirements
    task automatic step(input logic [15:0] a, input logic [7:0] d, input bit w, input string tag);
        bit hit;
        @(negedge clk);
        cpu_addr = a;
        cpu_data = d;
        cpu_wr   = w;
        @(posedge clk);
        #1;
        hit = w && (a == 16'h6000);
        if (hit) begin
            em[ep] = d;
            ep = (ep + 1) % 4;
        end
        check_state(hit, tag);
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst = 1'b1;
        cpu_wr = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #1;
        for (int i = 0; i < 4; i++) em[i] = 8'h00;
        ep = 0;
        check_state(1'b0, tag);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst      = 1'b1;
        cpu_addr = 16'h0000;
        cpu_data = 8'h00;
        cpu_wr   = 1'b0;
        for (int i = 0; i < 4; i++) em[i] = 8'h00;
        ep = 0;

        // R7: reset state
        repeat (3) @(posedge clk);
        #1;
        check_state(1'b0, "R7 reset state");
        @(negedge clk);
        rst = 1'b0;

        // R1 R3 R4 R8: 256 back-to-back loads, wrapping 64 times
        for (int d = 0; d < 256; d++) begin
            step(16'h6000, 8'(d * 37 + 11), 1'b1, "R1 R3 R4 R8 burst");
        end
        step(16'h0000, 8'h00, 1'b0, "R5 pulse ends");

        // R4: the fifth write overwrites register 0
        for (int k = 0; k < 5; k++) begin
            step(16'h6000, 8'(8'hA0 + k), 1'b1, "R4 fifth overwrites slot 0");
        end
        step(16'h6000, 8'h00, 1'b0, "R6 idle");

        // R2: single-bit neighbours of the load address
        for (int b = 0; b < 16; b++) begin
            step(16'h6000 ^ (16'h0001 << b), 8'hC3, 1'b1, "R2 bit neighbour");
        end
        // R2: low offsets and a spread across the window
        for (int k = 1; k < 32; k++) begin
            step(16'h6000 + 16'(k), 8'h3C, 1'b1, "R2 low offset");
        end
        for (int p = 0; p < 32; p++) begin
            step(16'h6080 + 16'(p * 256), 8'h99, 1'b1, "R2 window spread");
        end
        step(16'h7FFF, 8'h77, 1'b1, "R2 window top");

        // R2: pointer unaffected by misses, next load goes to the predicted slot
        step(16'h6000, 8'h11, 1'b1, "R2 R4 pointer held across misses");

        // R6: strobe low at the load address
        for (int k = 0; k < 8; k++) begin
            step(16'h6000, 8'(8'hF0 + k), 1'b0, "R6 strobe low");
        end
        step(16'h6000, 8'h22, 1'b1, "R6 pointer held while idle");

        // R5: isolated writes with idle gaps
        for (int k = 0; k < 6; k++) begin
            step(16'h6000, 8'(8'h40 + k), 1'b1, "R5 pulse after write");
            step(16'h6001, 8'h00, 1'b1, "R5 no pulse on miss");
            step(16'h6000, 8'h00, 1'b0, "R5 no pulse on idle");
        end

        // R9: reset mid-sequence, next write lands in register 0
        step(16'h6000, 8'h5A, 1'b1, "R9 partial load");
        do_reset("R7 R9 reset mid-sequence");
        step(16'h6000, 8'hE1, 1'b1, "R9 first write after reset");
        step(16'h6000, 8'hE2, 1'b1, "R9 second write after reset");
        step(16'h6000, 8'h00, 1'b0, "R9 idle");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule